// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block caches recent virtual-to-physical page translations so that most memory references avoid a page-table walk. Every slot can hold any translation. A lookup compares the requested virtual page number and address-space identifier against all slots at once. The response arrives one cycle later. A hit returns the frame number, the protection bits and the usage flags. A miss tells the surrounding logic to walk the tables and then write the result through the fill port.

Each slot is tagged with an address-space identifier. A context switch therefore needs no full invalidation. One input invalidates only the slots of a single identifier, and a second input invalidates every slot. Replacement follows least-recently-used order kept in hardware. Both hits and fills count as uses. A hit marks its slot as referenced, and a permitted write hit also marks it as modified.

The lookup and fill ports are valid/ready. A request is taken on a clock edge where both valid and ready are high. Both ready outputs drop in a cycle where either flush input is high, and they are high in every other cycle. The response side has no back-pressure: the response is valid for exactly one cycle, and the consumer must take it then.

Top module: `asid_tlb`

## Requirements
- R1: A lookup accepted in cycle t gives, in cycle t+1, rs_valid=1 and rs_hit=1 when a valid slot matches both the virtual page number and the identifier. With the hit, rs_pfn and rs_prot carry that slot's frame number and protection bits.
- R2: A lookup with no matching valid slot gives rs_hit=0, rs_fault=0, rs_ref=0, rs_mod=0, rs_pfn=0 and rs_prot=0. A slot with the same page number but a different identifier does not match.
- R3: A hit sets the slot's referenced flag. A write hit on a slot whose protection bit 0 is 1 (writable) also sets its modified flag. rs_ref and rs_mod report the flags after the update.
- R4: A write hit on a slot whose protection bit 0 is 0 gives rs_fault=1 and leaves the modified flag unchanged.
- R5: A fill with no matching key goes to the lowest-numbered invalid slot, when one exists. A filled slot is valid, with referenced and modified flags at 0.
- R6: A fill whose identifier and page number match a valid slot overwrites that slot, so no duplicate is created.
- R7: When all slots are valid, a fill with a new key replaces the least-recently-used slot.
- R8: A hit and a fill each make the slot they touch the most recently used.
- R9: flush_all invalidates every slot at the next edge.
- R10: flush_asid_en invalidates, at the next edge, exactly the slots whose identifier equals flush_asid_id.
- R11: lk_ready and fill_ready are 0 in a cycle with either flush input high, and 1 otherwise. A lookup and a fill in the same cycle both proceed. The lookup sees the slots as they were before the fill. The victim is chosen from the order before that cycle's uses. The fill is the more recent of the two uses, and its fields replace any flag update that the lookup makes to the same slot.
- R12: After reset all slots are invalid, the use order from most to least recent is slot 0 up to slot N-1, and rs_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request can be taken |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_asid | input | ASID_W | Current address-space identifier |
| lk_write | input | 1 | The access is a write |
| rs_valid | output | 1 | Response valid, one cycle after acceptance |
| rs_hit | output | 1 | Translation found |
| rs_fault | output | 1 | Write to a non-writable page |
| rs_pfn | output | PFN_W | Page frame number of the hit |
| rs_prot | output | PROT_W | Protection bits of the hit |
| rs_ref | output | 1 | Referenced flag after the access |
| rs_mod | output | 1 | Modified flag after the access |
| fill_valid | input | 1 | Fill request valid |
| fill_ready | output | 1 | Fill request can be taken |
| fill_vpn | input | VPN_W | Page number to install |
| fill_asid | input | ASID_W | Identifier to install |
| fill_pfn | input | PFN_W | Frame number to install |
| fill_prot | input | PROT_W | Protection bits to install (bit 0 = writable) |
| flush_all | input | 1 | Invalidate every slot |
| flush_asid_en | input | 1 | Invalidate the slots of one identifier |
| flush_asid_id | input | ASID_W | Identifier to invalidate |

## Verification
A lookup and a fill may be accepted on the same edge. The bench provokes this in directed cases: a fill of a key that is being looked up, a fill that evicts the slot being hit, and a write hit on a slot that the fill then overwrites. A long mixed phase adds more such cases, drawing keys from a small pool so that collisions and evictions are frequent. A behavioural model handles each such cycle in a fixed order: lookup result, victim choice from the old use order, lookup flag update, then the fill. Every response and every ready output is compared against this model each cycle.

// File: rtl/asid_tlb_pkg.sv
package asid_tlb_pkg;
  // position of the write-permission bit inside the protection field
  localparam int PROT_WR_BIT = 0;
  // source of a use-order update inside one cycle
  typedef enum logic [0:0] {TOUCH_LOOKUP = 1'b0, TOUCH_FILL = 1'b1} touch_src_e;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int N      = 16,
  parameter int VPN_W  = 20,
  parameter int ASID_W = 8,
  parameter int IW     = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]             slot_vld,
  input  logic [N-1:0][VPN_W-1:0]  slot_vpn,
  input  logic [N-1:0][ASID_W-1:0] slot_asid,
  input  logic [VPN_W-1:0]         key_vpn,
  input  logic [ASID_W-1:0]        key_asid,
  output logic [N-1:0]             hit_vec,
  output logic                     hit_any,
  output logic [IW-1:0]            hit_idx
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec[g] = slot_vld[g] && (slot_vpn[g] == key_vpn) && (slot_asid[g] == key_asid);
  end

  assign hit_any = |hit_vec;

  always_comb begin
    hit_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_idx = IW'(i);
    end
  end
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
  parameter int N  = 16,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  slot_vld,
  input  logic          use_a_en,
  input  logic [IW-1:0] use_a_idx,
  input  logic          use_b_en,
  input  logic [IW-1:0] use_b_idx,
  output logic [IW-1:0] victim_idx
);
  // age 0 = most recent, age N-1 = least recent; ages form a permutation
  logic [N-1:0][IW-1:0] age_q, age_mid, age_nxt;
  logic [N-1:0]         oldest_vec;
  logic                 free_found;

  always_comb begin
    age_mid = age_q;
    if (use_a_en) begin
      for (int i = 0; i < N; i++) begin
        if (IW'(i) == use_a_idx)                 age_mid[i] = '0;
        else if (age_q[i] < age_q[use_a_idx])    age_mid[i] = age_q[i] + IW'(1);
      end
    end
    age_nxt = age_mid;
    if (use_b_en) begin
      for (int i = 0; i < N; i++) begin
        if (IW'(i) == use_b_idx)                 age_nxt[i] = '0;
        else if (age_mid[i] < age_mid[use_b_idx]) age_nxt[i] = age_mid[i] + IW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) age_q[i] <= IW'(i);
    end else begin
      age_q <= age_nxt;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_old
    assign oldest_vec[g] = (age_q[g] == IW'(N - 1));
  end

  always_comb begin
    victim_idx = '0;
    free_found = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!slot_vld[i]) begin
        victim_idx = IW'(i);
        free_found = 1'b1;
      end
    end
    if (!free_found) begin
      for (int i = 0; i < N; i++) begin
        if (oldest_vec[i]) victim_idx = IW'(i);
      end
    end
  end

  // R7
  oldest_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(oldest_vec) == 1);
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import asid_tlb_pkg::*;
#(
  parameter int N      = 16,
  parameter int VPN_W  = 20,
  parameter int ASID_W = 8,
  parameter int PFN_W  = 16,
  parameter int PROT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic              lk_write,
  output logic              rs_valid,
  output logic              rs_hit,
  output logic              rs_fault,
  output logic [PFN_W-1:0]  rs_pfn,
  output logic [PROT_W-1:0] rs_prot,
  output logic              rs_ref,
  output logic              rs_mod,
  input  logic              fill_valid,
  output logic              fill_ready,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic [PROT_W-1:0] fill_prot,
  input  logic              flush_all,
  input  logic              flush_asid_en,
  input  logic [ASID_W-1:0] flush_asid_id
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]             ent_vld, ent_ref, ent_mod;
  logic [N-1:0][VPN_W-1:0]  ent_vpn;
  logic [N-1:0][ASID_W-1:0] ent_asid;
  logic [N-1:0][PFN_W-1:0]  ent_pfn;
  logic [N-1:0][PROT_W-1:0] ent_prot;

  logic          flush_any, lk_fire, fill_fire;
  logic [N-1:0]  lk_hit_vec, fill_hit_vec;
  logic          lk_hit, fill_hit;
  logic [IW-1:0] lk_idx, fill_idx, victim_idx, fill_slot;
  logic          wr_ok, set_mod;
  touch_src_e    last_src;

  assign flush_any  = flush_all | flush_asid_en;
  assign lk_ready   = ~flush_any;
  assign fill_ready = ~flush_any;
  assign lk_fire    = lk_valid & lk_ready;
  assign fill_fire  = fill_valid & fill_ready;

  tlb_match #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W), .IW(IW)) u_lk_match (
    .slot_vld(ent_vld), .slot_vpn(ent_vpn), .slot_asid(ent_asid),
    .key_vpn(lk_vpn), .key_asid(lk_asid),
    .hit_vec(lk_hit_vec), .hit_any(lk_hit), .hit_idx(lk_idx)
  );

  tlb_match #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W), .IW(IW)) u_fill_match (
    .slot_vld(ent_vld), .slot_vpn(ent_vpn), .slot_asid(ent_asid),
    .key_vpn(fill_vpn), .key_asid(fill_asid),
    .hit_vec(fill_hit_vec), .hit_any(fill_hit), .hit_idx(fill_idx)
  );

  tlb_lru #(.N(N), .IW(IW)) u_lru (
    .clk(clk), .rst_n(rst_n), .slot_vld(ent_vld),
    .use_a_en(lk_fire & lk_hit), .use_a_idx(lk_idx),
    .use_b_en(fill_fire), .use_b_idx(fill_slot),
    .victim_idx(victim_idx)
  );

  assign fill_slot = fill_hit ? fill_idx : victim_idx;
  assign wr_ok     = ent_prot[lk_idx][PROT_WR_BIT];
  assign set_mod   = lk_write & wr_ok;
  assign last_src  = fill_fire ? TOUCH_FILL : TOUCH_LOOKUP;

  // slot storage: flushes first, then lookup flag update, then fill (fill wins)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_vld  <= '0;
      ent_ref  <= '0;
      ent_mod  <= '0;
      ent_vpn  <= '0;
      ent_asid <= '0;
      ent_pfn  <= '0;
      ent_prot <= '0;
    end else if (flush_all) begin
      ent_vld <= '0;
    end else if (flush_asid_en) begin
      for (int i = 0; i < N; i++) begin
        if (ent_asid[i] == flush_asid_id) ent_vld[i] <= 1'b0;
      end
    end else begin
      if (lk_fire && lk_hit) begin
        ent_ref[lk_idx] <= 1'b1;
        if (set_mod) ent_mod[lk_idx] <= 1'b1;
      end
      if (last_src == TOUCH_FILL) begin
        ent_vld[fill_slot]  <= 1'b1;
        ent_ref[fill_slot]  <= 1'b0;
        ent_mod[fill_slot]  <= 1'b0;
        ent_vpn[fill_slot]  <= fill_vpn;
        ent_asid[fill_slot] <= fill_asid;
        ent_pfn[fill_slot]  <= fill_pfn;
        ent_prot[fill_slot] <= fill_prot;
      end
    end
  end

  // registered response
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_valid <= 1'b0;
      rs_hit   <= 1'b0;
      rs_fault <= 1'b0;
      rs_pfn   <= '0;
      rs_prot  <= '0;
      rs_ref   <= 1'b0;
      rs_mod   <= 1'b0;
    end else begin
      rs_valid <= lk_fire;
      rs_hit   <= lk_fire & lk_hit;
      rs_fault <= lk_fire & lk_hit & lk_write & ~wr_ok;
      rs_pfn   <= (lk_fire & lk_hit) ? ent_pfn[lk_idx]  : '0;
      rs_prot  <= (lk_fire & lk_hit) ? ent_prot[lk_idx] : '0;
      rs_ref   <= lk_fire & lk_hit;
      rs_mod   <= lk_fire & lk_hit & (ent_mod[lk_idx] | set_mod);
    end
  end

  // R4
  fault_is_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rs_fault |-> (rs_valid && rs_hit && rs_ref));
  // R2
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_hit) |-> (rs_pfn == '0 && !rs_ref && !rs_mod && !rs_fault));
  // R6
  no_dup_lookup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_hit_vec));
  // R6
  no_dup_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fill_hit_vec));
  // R9
  flush_all_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (ent_vld == '0));
  // R11
  flush_no_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_any |=> !rs_valid);
endmodule

// File: tb/asid_tlb_tb.sv
`timescale 1ns/1ps
module asid_tlb_tb;
  localparam int N = 16, VPN_W = 20, ASID_W = 8, PFN_W = 16, PROT_W = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lk_valid = 0, lk_write = 0, fill_valid = 0, flush_all = 0, flush_asid_en = 0;
  logic [VPN_W-1:0] lk_vpn = '0, fill_vpn = '0;
  logic [ASID_W-1:0] lk_asid = '0, fill_asid = '0, flush_asid_id = '0;
  logic [PFN_W-1:0] fill_pfn = '0;
  logic [PROT_W-1:0] fill_prot = '0;
  logic lk_ready, fill_ready, rs_valid, rs_hit, rs_fault, rs_ref, rs_mod;
  logic [PFN_W-1:0] rs_pfn;
  logic [PROT_W-1:0] rs_prot;

  always #10 clk = ~clk;

  asid_tlb #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W), .PFN_W(PFN_W), .PROT_W(PROT_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_vpn(lk_vpn), .lk_asid(lk_asid), .lk_write(lk_write),
    .rs_valid(rs_valid), .rs_hit(rs_hit), .rs_fault(rs_fault), .rs_pfn(rs_pfn), .rs_prot(rs_prot),
    .rs_ref(rs_ref), .rs_mod(rs_mod),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_vpn(fill_vpn), .fill_asid(fill_asid),
    .fill_pfn(fill_pfn), .fill_prot(fill_prot),
    .flush_all(flush_all), .flush_asid_en(flush_asid_en), .flush_asid_id(flush_asid_id)
  );

  int errors = 0, checks = 0;
  string cur_req = "R12 reset";

  // behavioural model
  logic [VPN_W-1:0]  m_vpn [N];
  logic [ASID_W-1:0] m_asid [N];
  logic [PFN_W-1:0]  m_pfn [N];
  logic [PROT_W-1:0] m_prot [N];
  logic m_vld [N], m_ref [N], m_mod [N];
  int   order_q [$];           // front = most recent
  logic e_valid;
  logic [21:0] e_resp;

  function automatic void touch(int k);
    for (int i = 0; i < order_q.size(); i++) begin
      if (order_q[i] == k) begin
        order_q.delete(i);
        break;
      end
    end
    order_q.push_front(k);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      order_q.delete();
      for (int i = 0; i < N; i++) begin
        m_vld[i] = 0; m_ref[i] = 0; m_mod[i] = 0;
        m_vpn[i] = '0; m_asid[i] = '0; m_pfn[i] = '0; m_prot[i] = '0;
        order_q.push_back(i);
      end
      e_valid = 0;
      e_resp  = '0;
    end else begin
      automatic logic fl = flush_all | flush_asid_en;
      checks++;
      if (lk_ready !== !fl || fill_ready !== !fl) begin
        errors++;
        $display("FAIL R11 ready actual=%b%b expected=%b%b", lk_ready, fill_ready, !fl, !fl);
      end
      e_valid = 0;
      e_resp  = '0;
      if (flush_all) begin
        for (int i = 0; i < N; i++) m_vld[i] = 0;
      end else if (flush_asid_en) begin
        for (int i = 0; i < N; i++) if (m_asid[i] == flush_asid_id) m_vld[i] = 0;
      end else begin
        automatic int h = -1, f = -1, victim = -1;
        for (int i = 0; i < N; i++) begin
          if (m_vld[i] && m_vpn[i] == lk_vpn && m_asid[i] == lk_asid) h = i;
          if (m_vld[i] && m_vpn[i] == fill_vpn && m_asid[i] == fill_asid) f = i;
        end
        for (int i = N - 1; i >= 0; i--) if (!m_vld[i]) victim = i;
        if (victim < 0) victim = order_q[$];
        if (lk_valid) begin
          e_valid = 1;
          if (h >= 0) begin
            automatic logic ok = m_prot[h][0];
            automatic logic flt = lk_write && !ok;
            m_ref[h] = 1;
            if (lk_write && ok) m_mod[h] = 1;
            e_resp = {1'b1, flt, m_pfn[h], m_prot[h], 1'b1, m_mod[h]};
            touch(h);
          end
        end
        if (fill_valid) begin
          automatic int s = (f >= 0) ? f : victim;
          m_vld[s] = 1; m_ref[s] = 0; m_mod[s] = 0;
          m_vpn[s] = fill_vpn; m_asid[s] = fill_asid; m_pfn[s] = fill_pfn; m_prot[s] = fill_prot;
          touch(s);
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (rs_valid !== e_valid) begin
        errors++;
        $display("FAIL %s rs_valid actual=%b expected=%b", cur_req, rs_valid, e_valid);
      end else if (e_valid) begin
        automatic logic [21:0] act = {rs_hit, rs_fault, rs_pfn, rs_prot, rs_ref, rs_mod};
        checks++;
        if (act !== e_resp) begin
          errors++;
          $display("FAIL %s response actual=%h expected=%h", cur_req, act, e_resp);
        end
      end
    end
  end

  task automatic clr();
    lk_valid = 0; lk_write = 0; fill_valid = 0; flush_all = 0; flush_asid_en = 0;
  endtask

  task automatic op(input logic lv, input int lvpn, input int lasid, input logic lw,
                    input logic fv, input int fvpn, input int fasid, input int fpfn, input int fprot);
    @(negedge clk);
    clr();
    lk_valid = lv; lk_vpn = VPN_W'(lvpn); lk_asid = ASID_W'(lasid); lk_write = lw;
    fill_valid = fv; fill_vpn = VPN_W'(fvpn); fill_asid = ASID_W'(fasid);
    fill_pfn = PFN_W'(fpfn); fill_prot = PROT_W'(fprot);
  endtask

  task automatic lk(input int v, input int a, input logic w);
    op(1, v, a, w, 0, 0, 0, 0, 0);
  endtask

  task automatic fl(input int v, input int a, input int p, input int pr);
    op(0, 0, 0, 0, 1, v, a, p, pr);
  endtask

  task automatic idle();
    op(0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur_req = "R12 reset";
    idle();
    lk(20'h100, 1, 0);
    idle();

    cur_req = "R5 fill free";
    fl(20'h100, 1, 16'h0A01, 1);
    fl(20'h200, 1, 16'h0A02, 0);
    fl(20'h100, 2, 16'h0B01, 1);
    cur_req = "R1 hit";
    lk(20'h100, 1, 0);
    lk(20'h100, 2, 0);
    cur_req = "R2 miss";
    lk(20'h100, 3, 0);
    lk(20'h300, 1, 0);
    cur_req = "R3 write hit";
    lk(20'h100, 1, 1);
    lk(20'h100, 1, 0);
    cur_req = "R4 protection fault";
    lk(20'h200, 1, 1);
    lk(20'h200, 1, 0);
    cur_req = "R6 refill";
    fl(20'h100, 1, 16'h0C01, 1);
    lk(20'h100, 1, 0);

    cur_req = "R7 evict";
    for (int i = 0; i < N; i++) fl(20'h400 + i, 5, 16'h1000 + i, 1);
    lk(20'h100, 1, 0);
    lk(20'h400, 5, 0);
    cur_req = "R8 hit refresh";
    lk(20'h401, 5, 0);
    fl(20'h500, 5, 16'h2000, 1);
    fl(20'h501, 5, 16'h2001, 1);
    lk(20'h401, 5, 0);
    lk(20'h402, 5, 0);

    cur_req = "R11 concurrent";
    op(1, 20'h403, 5, 1, 1, 20'h403, 5, 16'h3003, 1);
    lk(20'h403, 5, 0);
    op(1, 20'h600, 5, 0, 1, 20'h600, 5, 16'h3600, 1);
    lk(20'h600, 5, 0);
    op(1, 20'h404, 5, 0, 1, 20'h700, 5, 16'h3700, 1);
    lk(20'h404, 5, 0);

    cur_req = "R10 flush asid";
    fl(20'h100, 7, 16'h0707, 1);
    @(negedge clk); clr(); flush_asid_en = 1; flush_asid_id = 8'd5; lk_valid = 1; lk_vpn = 20'h405; lk_asid = 8'd5;
    lk(20'h405, 5, 0);
    lk(20'h100, 7, 0);
    cur_req = "R9 flush all";
    @(negedge clk); clr(); flush_all = 1; fill_valid = 1; fill_vpn = 20'h900;
    lk(20'h100, 7, 0);
    lk(20'h900, 0, 0);

    cur_req = "R11 mixed";
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      clr();
      lk_valid = ($urandom_range(0, 9) < 7);
      lk_vpn = VPN_W'($urandom_range(0, 23));
      lk_asid = ASID_W'($urandom_range(0, 2));
      lk_write = $urandom_range(0, 1);
      fill_valid = ($urandom_range(0, 9) < 4);
      fill_vpn = VPN_W'($urandom_range(0, 23));
      fill_asid = ASID_W'($urandom_range(0, 2));
      fill_pfn = PFN_W'($urandom);
      fill_prot = PROT_W'($urandom_range(0, 3));
      flush_all = ($urandom_range(0, 199) == 0);
      flush_asid_en = ($urandom_range(0, 99) < 2);
      flush_asid_id = ASID_W'($urandom_range(0, 2));
    end
    idle();
    idle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule